// File: doc/BRIEF.md
# Prioritized Exception Entry Sequencer

This block sits beside a processor's register file and program counter. Each cycle it takes up to seven exception request lines, the address of the next instruction and the current status word. It drops any interrupt request that the status word's mask bits disable, then picks one survivor by a fixed ranking.

One clock edge later it presents a complete, atomic entry:
- a write of the return address into the link register of the mode being entered;
- a write of the old status word into that mode's saved status register;
- a new status word with the mode field changed, the compact-instruction state cleared and the interrupt masks raised;
- a new program counter taken from the exception's fixed vector slot.

All four writes appear together, so the rest of the core never observes an entry half-done. Decoding, pipeline control and memory are outside the block.

The status word is laid out as follows:
- bits [4:0] are the mode field;
- bit 5 is the compact-instruction state bit;
- bit 6 is the fast-interrupt mask;
- bit 7 is the normal-interrupt mask;
- bits [31:8] pass through unchanged.

Top module: `exc_entry_seq`

## Requirements
- R1: When several unmasked requests are present in one cycle, exactly one entry is taken, in this order from highest to lowest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. Undefined instruction wins over software interrupt.
- R2: On entry, `lr_data` equals the `next_pc` sampled in the request cycle, and `bank_mode` names the mode being entered.
- R3: On entry, `spsr_data` equals the `cur_cpsr` sampled in the request cycle.
- R4: The mode field of `cpsr_data[4:0]` and the vector offset in `pc_data` depend on the exception:
  - reset → 10011 at 0x00;
  - undefined instruction → 11011 at 0x04;
  - software interrupt → 10011 at 0x08;
  - prefetch abort → 10111 at 0x0C;
  - data abort → 10111 at 0x10;
  - normal interrupt → 10010 at 0x18;
  - fast interrupt → 10001 at 0x1C.

  The user mode 10000 is never entered.
- R5: `cpsr_data[5]` (compact-instruction state) is 0 on every entry.
- R6: `cpsr_data[7]` is 1 on every entry. `cpsr_data[6]` is 1 after reset or fast-interrupt entry, and otherwise keeps its old value.
- R7: A normal interrupt is ignored while `cur_cpsr[7]` is 1, and a fast interrupt is ignored while `cur_cpsr[6]` is 1. A masked request causes no write, and the next lower request is taken in its place.
- R8: With `hivec` high, vectors are based at 0xFFFF0000; with `hivec` low, they are based at 0x00000000.
- R9: The four write strobes rise together one cycle after the request cycle, and stay low after a cycle with no unmasked request. On entry, `cpsr_data[31:8]` equals `cur_cpsr[31:8]`.
- R10: While `rst_n` is low at a clock edge, all strobes are 0 in the following cycle, whatever the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rst | input | 1 | Reset exception request |
| req_dabort | input | 1 | Data abort request |
| req_fast | input | 1 | Fast interrupt request |
| req_intr | input | 1 | Normal interrupt request |
| req_pabort | input | 1 | Prefetch abort request |
| req_undef | input | 1 | Undefined instruction request |
| req_swint | input | 1 | Software interrupt request |
| hivec | input | 1 | Select high vector base |
| next_pc | input | 32 | Address of the next instruction |
| cur_cpsr | input | 32 | Current status word |
| lr_we | output | 1 | Banked link register write strobe |
| spsr_we | output | 1 | Banked saved status write strobe |
| cpsr_we | output | 1 | Current status write strobe |
| pc_we | output | 1 | Program counter load strobe |
| bank_mode | output | 5 | Mode whose banked registers are written |
| lr_data | output | 32 | Return address to store |
| spsr_data | output | 32 | Old status word to store |
| cpsr_data | output | 32 | New status word |
| pc_data | output | 32 | Vector address |

## Verification
Two functions can fall in the same cycle: priority selection and mask filtering.

The bench provokes this by raising several requests together while one or both mask bits are set. For example, it raises a masked fast interrupt alongside a normal interrupt, or a masked normal interrupt alongside a prefetch abort.

Each case is judged from the mode, vector and status word that appear one cycle later. The preserved or forced fast-interrupt mask shows which of the overlapping rules decided the outcome.

// File: rtl/exc_pkg.sv
// Shared types for the exception entry sequencer.
// Assumes a 5-bit mode field in bits [4:0] of the status word.
package exc_pkg;

    localparam int NUM_SRC = 7;
    localparam int PSR_T   = 5;
    localparam int PSR_F   = 6;
    localparam int PSR_I   = 7;

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    // Index order is also the priority order, 0 highest.
    typedef enum logic [2:0] {
        EXC_RST  = 3'd0,
        EXC_DABT = 3'd1,
        EXC_FIQ  = 3'd2,
        EXC_IRQ  = 3'd3,
        EXC_PABT = 3'd4,
        EXC_UND  = 3'd5,
        EXC_SWI  = 3'd6
    } exc_kind_e;

endpackage

// File: rtl/exc_prio_arb.sv
// Fixed-priority picker: bit 0 is the highest-ranked request.
// Produces a one-hot grant, the encoded winner index and an any flag.
// Assumes requests are already filtered by masks.
module exc_prio_arb #(
    parameter int N  = 7,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Walk from highest rank downward, granting the first request seen.
    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !seen) begin
                grant[i] = 1'b1;
                idx      = IW'(i);
            end
            seen = seen | req[i];
        end
        any = seen;
    end

endmodule

// File: rtl/exc_vec_map.sv
// Maps the winning exception kind to its target mode, vector offset
// and whether the fast-interrupt mask must be forced on.
// Purely combinational.
module exc_vec_map
    import exc_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  exc_kind_e        kind,
    output cpu_mode_e        mode,
    output logic [OFS_W-1:0] offset,
    output logic             set_f
);

    // Look up mode, slot and fast-mask forcing for each kind.
    always_comb begin
        mode   = MODE_SVC;
        offset = '0;
        set_f  = 1'b0;
        case (kind)
            EXC_RST:  begin mode = MODE_SVC; offset = OFS_W'(8'h00); set_f = 1'b1; end
            EXC_UND:  begin mode = MODE_UND; offset = OFS_W'(8'h04); end
            EXC_SWI:  begin mode = MODE_SVC; offset = OFS_W'(8'h08); end
            EXC_PABT: begin mode = MODE_ABT; offset = OFS_W'(8'h0C); end
            EXC_DABT: begin mode = MODE_ABT; offset = OFS_W'(8'h10); end
            EXC_IRQ:  begin mode = MODE_IRQ; offset = OFS_W'(8'h18); end
            EXC_FIQ:  begin mode = MODE_FIQ; offset = OFS_W'(8'h1C); set_f = 1'b1; end
            default:  begin mode = MODE_SVC; offset = '0; end
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer.
// Masks interrupt requests with the status word, ranks the rest, and
// registers one atomic entry: banked return address, banked old status,
// new status and vector load, all strobed in the same cycle.
// Assumes the requests and next_pc are valid for the cycle presented;
// reset is synchronous, active low.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PSR_W      = 32,
    parameter int          OFS_W      = 8,
    parameter logic [31:0] HIVEC_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rst,
    input  logic              req_dabort,
    input  logic              req_fast,
    input  logic              req_intr,
    input  logic              req_pabort,
    input  logic              req_undef,
    input  logic              req_swint,
    input  logic              hivec,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [PSR_W-1:0]  cur_cpsr,
    output logic              lr_we,
    output logic              spsr_we,
    output logic              cpsr_we,
    output logic              pc_we,
    output logic [4:0]        bank_mode,
    output logic [ADDR_W-1:0] lr_data,
    output logic [PSR_W-1:0]  spsr_data,
    output logic [PSR_W-1:0]  cpsr_data,
    output logic [ADDR_W-1:0] pc_data
);

    localparam int IW = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] req_vec;
    logic [NUM_SRC-1:0] grant;
    logic [IW-1:0]      win_idx;
    logic               win_any;
    cpu_mode_e          win_mode;
    logic [OFS_W-1:0]   win_ofs;
    logic               win_set_f;
    logic [PSR_W-1:0]   new_cpsr;
    logic [ADDR_W-1:0]  vec_addr;
    logic               ent_q;

    // Gate interrupt lines by their masks and order requests by rank.
    always_comb begin
        req_vec           = '0;
        req_vec[EXC_RST]  = req_rst;
        req_vec[EXC_DABT] = req_dabort;
        req_vec[EXC_FIQ]  = req_fast & ~cur_cpsr[PSR_F];
        req_vec[EXC_IRQ]  = req_intr & ~cur_cpsr[PSR_I];
        req_vec[EXC_PABT] = req_pabort;
        req_vec[EXC_UND]  = req_undef;
        req_vec[EXC_SWI]  = req_swint;
    end

    exc_prio_arb #(.N(NUM_SRC)) u_arb (
        .req   (req_vec),
        .grant (grant),
        .idx   (win_idx),
        .any   (win_any)
    );

    exc_vec_map #(.OFS_W(OFS_W)) u_map (
        .kind   (exc_kind_e'(win_idx)),
        .mode   (win_mode),
        .offset (win_ofs),
        .set_f  (win_set_f)
    );

    // Form the status word the handler starts with.
    always_comb begin
        new_cpsr        = cur_cpsr;
        new_cpsr[4:0]   = win_mode;
        new_cpsr[PSR_T] = 1'b0;
        new_cpsr[PSR_I] = 1'b1;
        if (win_set_f) new_cpsr[PSR_F] = 1'b1;
    end

    // Form the vector address from the selected base and slot offset.
    always_comb begin
        vec_addr = (hivec ? HIVEC_BASE[ADDR_W-1:0] : '0) | ADDR_W'(win_ofs);
    end

    // Register the whole entry so every write lands in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q     <= 1'b0;
            bank_mode <= MODE_SVC;
            lr_data   <= '0;
            spsr_data <= '0;
            cpsr_data <= '0;
            pc_data   <= '0;
        end else begin
            ent_q <= win_any;
            if (win_any) begin
                bank_mode <= win_mode;
                lr_data   <= next_pc;
                spsr_data <= cur_cpsr;
                cpsr_data <= new_cpsr;
                pc_data   <= vec_addr;
            end
        end
    end

    assign lr_we   = ent_q;
    assign spsr_we = ent_q;
    assign cpsr_we = ent_q;
    assign pc_we   = ent_q;

    AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_rst |=> (bank_mode == MODE_SVC && pc_data[7:0] == 8'h00)); // R1
    AST_LR_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_vec) |=> (lr_data == $past(next_pc))); // R2
    AST_SPSR_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_vec) |=> (spsr_data == $past(cur_cpsr))); // R3
    AST_PRIVILEGED: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_we |-> (cpsr_data[4:0] != MODE_USR)); // R4
    AST_THUMB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_we |-> !cpsr_data[PSR_T]); // R5
    AST_IMASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_we |-> cpsr_data[PSR_I]); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_intr && cur_cpsr[PSR_I] && !req_rst && !req_dabort && !req_fast
         && !req_pabort && !req_undef && !req_swint) |=> !cpsr_we); // R7
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_vec) |=> !pc_we); // R9

endmodule

// File: tb/tb_exc_entry_seq.sv
// Self-checking bench: a vector table walked by one loop, then directed
// reset cases. Inputs change on negedge, outputs are read one full
// cycle later on the next negedge.
module tb_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_rst, req_dabort, req_fast, req_intr;
    logic        req_pabort, req_undef, req_swint, hivec;
    logic [31:0] next_pc, cur_cpsr;
    logic        lr_we, spsr_we, cpsr_we, pc_we;
    logic [4:0]  bank_mode;
    logic [31:0] lr_data, spsr_data, cpsr_data, pc_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n),
        .req_rst(req_rst), .req_dabort(req_dabort), .req_fast(req_fast),
        .req_intr(req_intr), .req_pabort(req_pabort), .req_undef(req_undef),
        .req_swint(req_swint), .hivec(hivec), .next_pc(next_pc),
        .cur_cpsr(cur_cpsr), .lr_we(lr_we), .spsr_we(spsr_we),
        .cpsr_we(cpsr_we), .pc_we(pc_we), .bank_mode(bank_mode),
        .lr_data(lr_data), .spsr_data(spsr_data), .cpsr_data(cpsr_data),
        .pc_data(pc_data)
    );

    // req bits: [6] reset [5] data abort [4] fast [3] normal [2] prefetch [1] undef [0] swint
    typedef struct packed {
        logic [6:0]  req;
        logic        ib;
        logic        fb;
        logic        hv;
        logic        take;
        logic [4:0]  mode;
        logic [31:0] pc;
        logic        fx;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [0:NV-1] = '{
        '{7'b0000001, 1'b0, 1'b0, 1'b0, 1'b1, 5'b10011, 32'h0000_0008, 1'b0},
        '{7'b0000010, 1'b0, 1'b0, 1'b0, 1'b1, 5'b11011, 32'h0000_0004, 1'b0},
        '{7'b0000011, 1'b0, 1'b0, 1'b0, 1'b1, 5'b11011, 32'h0000_0004, 1'b0},
        '{7'b0000100, 1'b0, 1'b0, 1'b0, 1'b1, 5'b10111, 32'h0000_000C, 1'b0},
        '{7'b0001000, 1'b0, 1'b0, 1'b0, 1'b1, 5'b10010, 32'h0000_0018, 1'b0},
        '{7'b0001000, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00000, 32'h0000_0000, 1'b0},
        '{7'b0001100, 1'b1, 1'b0, 1'b0, 1'b1, 5'b10111, 32'h0000_000C, 1'b0},
        '{7'b0010000, 1'b0, 1'b0, 1'b0, 1'b1, 5'b10001, 32'h0000_001C, 1'b1},
        '{7'b0010000, 1'b0, 1'b1, 1'b0, 1'b0, 5'b00000, 32'h0000_0000, 1'b1},
        '{7'b0011000, 1'b0, 1'b1, 1'b0, 1'b1, 5'b10010, 32'h0000_0018, 1'b1},
        '{7'b0100000, 1'b0, 1'b0, 1'b0, 1'b1, 5'b10111, 32'h0000_0010, 1'b0},
        '{7'b0111111, 1'b0, 1'b0, 1'b0, 1'b1, 5'b10111, 32'h0000_0010, 1'b0},
        '{7'b1111111, 1'b0, 1'b0, 1'b0, 1'b1, 5'b10011, 32'h0000_0000, 1'b1},
        '{7'b1000000, 1'b1, 1'b1, 1'b0, 1'b1, 5'b10011, 32'h0000_0000, 1'b1},
        '{7'b0000001, 1'b0, 1'b0, 1'b1, 1'b1, 5'b10011, 32'hFFFF_0008, 1'b0},
        '{7'b0010000, 1'b0, 1'b0, 1'b1, 1'b1, 5'b10001, 32'hFFFF_001C, 1'b1},
        '{7'b0000000, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 32'h0000_0000, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive_req(input logic [6:0] r);
        {req_rst, req_dabort, req_fast, req_intr, req_pabort, req_undef, req_swint} = r;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        hivec    = 1'b0;
        next_pc  = 32'h0;
        cur_cpsr = 32'hA000_0030;
        drive_req(7'b0000001);
        repeat (3) @(negedge clk);
        // R10: strobes stay low during reset despite a pending request
        chk("R10 strobes in reset", {28'h0, lr_we, spsr_we, cpsr_we, pc_we}, 32'h0);
        rst_n = 1'b1;
        drive_req(7'b0000000);
        @(negedge clk);
        chk("R9 idle after reset", {31'h0, pc_we}, 32'h0);

        // Walk the vector table.
        for (int i = 0; i < NV; i++) begin
            logic [31:0] cin, cexp;
            cin      = {24'hA0_0000, VEC[i].ib, VEC[i].fb, 1'b1, 5'b10000};
            cexp     = {24'hA0_0000, 1'b1, VEC[i].fx, 1'b0, VEC[i].mode};
            drive_req(VEC[i].req);
            hivec    = VEC[i].hv;
            cur_cpsr = cin;
            next_pc  = 32'h1000_0000 + 32'(i * 4);
            @(negedge clk);
            chk("R7/R9 strobes", {28'h0, lr_we, spsr_we, cpsr_we, pc_we},
                VEC[i].take ? 32'hF : 32'h0);
            if (VEC[i].take) begin
                chk("R1/R4 bank mode", {27'h0, bank_mode}, {27'h0, VEC[i].mode});
                chk("R4/R8 vector", pc_data, VEC[i].pc);
                chk("R2 link value", lr_data, 32'h1000_0000 + 32'(i * 4));
                chk("R3 saved status", spsr_data, cin);
                chk("R5/R6 new status", cpsr_data, cexp);
            end
        end

        // Directed: reset taken while an entry request is pending (R10).
        drive_req(7'b1000000);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 reset overrides entry", {28'h0, lr_we, spsr_we, cpsr_we, pc_we}, 32'h0);
        rst_n = 1'b1;
        drive_req(7'b0000000);
        @(negedge clk);
        chk("R9 idle after mid-run reset", {31'h0, cpsr_we}, 32'h0);

        // Directed: both masks set, both interrupts pending, nothing else.
        cur_cpsr = 32'h0000_00D0;
        drive_req(7'b0011000);
        @(negedge clk);
        chk("R7 both masked", {28'h0, lr_we, spsr_we, cpsr_we, pc_we}, 32'h0);
        drive_req(7'b0000000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule